// File: doc/BRIEF.md
# Peripheral Interrupt Level Router

This block collects up to 32 peripheral interrupt request lines and steers each of them onto one of nine general-purpose core event levels, numbered 7 to 15. Each source has a 4-bit routing code, so any number of sources may share one level. Each core level output is the OR of every unmasked request whose code selects that level. That OR is registered once before it leaves the block. Software reads a status word that mirrors the raw request lines, which tells it which peripheral raised a shared level.

A separate wakeup path works without reference to the mask. When the core reports that it is idle, any request whose wakeup-enable bit is set raises the wakeup output at once. All control words sit behind a simple single-cycle register port. Writes take effect on the next clock edge, and reads come back combinationally.

Top module: `irq_level_router`

## Requirements
- R1: After a synchronous reset, the mask word and the wakeup-enable word read as zero and every level output is low.
- R2: After reset, the routing codes are: sources 0..6 to level 7, 7..8 to level 8, 9..12 to level 9, 13..15 to level 10, 16..18 to level 11, 19..20 to level 12, 21..23 to level 13, and 24..31 to level 7.
- R3: Routing words sit at addresses 4..7. The word at address 4+w holds sources 8w..8w+7, and source 8w+f uses bits [4f+3:4f]. A code c selects level 7+c. Written values read back unchanged.
- R4: lvl_irq_o bit k (level 7+k) goes high in the cycle after any source is requested, unmasked and coded k. It drops in the cycle after no such source remains.
- R5: A source whose mask bit (address 0) is 0 drives no level output, even while it is requesting.
- R6: Several sources coded to the same level produce a single OR on that level. A level never shows more active bits than there were unmasked requests.
- R7: A read of address 1 returns the raw request lines in the same cycle, whatever the mask holds.
- R8: Writes to address 1 change no register. Status still mirrors the requests afterwards.
- R9: A source coded 9..15 drives no level output.
- R10: wake_o equals idle_i AND the OR of (request AND wakeup-enable bit, address 2). It is combinational and independent of the mask.
- R11: The mask (address 0) and wakeup-enable (address 2) words read back what was written. Address 3 reads as zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 32 | Raw peripheral request lines, level-sensitive |
| idle_i | input | 1 | Core is idle |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational |
| lvl_irq_o | output | 9 | Registered level requests, bit k is level 7+k |
| wake_o | output | 1 | Wakeup request to power control |

## Verification
Read data and wake_o are due in the same cycle as the address, request or idle change that causes them. The level outputs are due one clock after the request, mask or code that produces them. A register write shows up on read data one cycle later and on the levels two cycles later. The bench drives inputs at the falling edge and compares all three outputs 2 ns later against a behavioural model. The model updates its registers and its expected level word at each rising edge from the inputs present there, so each latency is counted exactly once.

// File: rtl/pim_pkg.sv
package pim_pkg;
    localparam int SRC_N          = 32;
    localparam int LVL_N          = 9;
    localparam int CODE_W         = 4;
    localparam int WORD_W         = 32;
    localparam int CODES_PER_WORD = WORD_W / CODE_W;
    localparam int ASG_WORDS      = SRC_N / CODES_PER_WORD;
    localparam int ADDR_W         = 3;
    localparam int IDX_W          = $clog2(ASG_WORDS);
    localparam int CODE_BITS      = SRC_N * CODE_W;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [ADDR_W-1:0] {
        ADR_MASK   = 3'd0,
        ADR_STATUS = 3'd1,
        ADR_WAKE   = 3'd2,
        ADR_SPARE  = 3'd3,
        ADR_ASG0   = 3'd4
    } adr_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } bus_req_t;

    function automatic code_t reset_code(input int src);
        if (src <= 6)       return code_t'(0);
        else if (src <= 8)  return code_t'(1);
        else if (src <= 12) return code_t'(2);
        else if (src <= 15) return code_t'(3);
        else if (src <= 18) return code_t'(4);
        else if (src <= 20) return code_t'(5);
        else if (src <= 23) return code_t'(6);
        else                return code_t'(0);
    endfunction

    function automatic logic [CODE_BITS-1:0] reset_codes();
        logic [CODE_BITS-1:0] v;
        v = '0;
        for (int s = 0; s < SRC_N; s++) v[s*CODE_W +: CODE_W] = reset_code(s);
        return v;
    endfunction

    function automatic logic is_asg(input logic [ADDR_W-1:0] a);
        return a >= ADDR_W'(ADR_ASG0);
    endfunction
endpackage

// File: rtl/pim_regs.sv
module pim_regs
    import pim_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  bus_req_t             bus,
    input  logic [SRC_N-1:0]     irq_raw,
    output logic [SRC_N-1:0]     mask_q,
    output logic [SRC_N-1:0]     wake_q,
    output logic [CODE_BITS-1:0] code_q,
    output logic [WORD_W-1:0]    rdata
);
    logic [IDX_W-1:0] asg_idx;
    assign asg_idx = bus.addr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            wake_q <= '0;
            code_q <= reset_codes();
        end else if (bus.we) begin
            case (bus.addr)
                ADR_MASK: mask_q <= bus.wdata[SRC_N-1:0];
                ADR_WAKE: wake_q <= bus.wdata[SRC_N-1:0];
                default: begin
                    if (is_asg(bus.addr))
                        code_q[asg_idx*WORD_W +: WORD_W] <= bus.wdata;
                end
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (bus.addr)
            ADR_MASK:   rdata = WORD_W'(mask_q);
            ADR_STATUS: rdata = WORD_W'(irq_raw);
            ADR_WAKE:   rdata = WORD_W'(wake_q);
            default: begin
                if (is_asg(bus.addr)) rdata = code_q[asg_idx*WORD_W +: WORD_W];
            end
        endcase
    end

    // R11
    mask_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus.we && bus.addr == ADDR_W'(ADR_MASK)) |=> (mask_q == $past(bus.wdata)));

    // R8
    codes_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus.we && is_asg(bus.addr)) |=> $stable(code_q));
endmodule

// File: rtl/pim_route.sv
module pim_route
    import pim_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SRC_N-1:0]     irq_raw,
    input  logic [SRC_N-1:0]     mask_q,
    input  logic [CODE_BITS-1:0] code_q,
    output logic [LVL_N-1:0]     lvl_q
);
    logic [SRC_N-1:0] live;
    logic [LVL_N-1:0] hit;

    assign live = irq_raw & mask_q;

    for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
        logic [SRC_N-1:0] sel;
        for (genvar s = 0; s < SRC_N; s++) begin : g_src
            assign sel[s] = (code_q[s*CODE_W +: CODE_W] == CODE_W'(l));
        end
        assign hit[l] = |(live & sel);
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= hit;
    end

    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq_raw & mask_q) == '0) |=> (lvl_q == '0));

    // R6
    lvl_count_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(lvl_q) <= $countones($past(irq_raw & mask_q))));
endmodule

// File: rtl/pim_wake.sv
module pim_wake
    import pim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             idle_i,
    input  logic [SRC_N-1:0] irq_raw,
    input  logic [SRC_N-1:0] wake_q,
    output logic             wake_o
);
    assign wake_o = idle_i & (|(irq_raw & wake_q));

    // R10
    wake_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !idle_i |-> !wake_o);

    // R10
    wake_none_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_q == '0) |-> !wake_o);
endmodule

// File: rtl/irq_level_router.sv
module irq_level_router
    import pim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       irq_i,
    input  logic              idle_i,
    input  logic              bus_we_i,
    input  logic [2:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic [8:0]        lvl_irq_o,
    output logic              wake_o
);
    bus_req_t             bus;
    logic [SRC_N-1:0]     mask_q;
    logic [SRC_N-1:0]     wake_q;
    logic [CODE_BITS-1:0] code_q;

    assign bus.we    = bus_we_i;
    assign bus.addr  = bus_addr_i;
    assign bus.wdata = bus_wdata_i;

    pim_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus),
        .irq_raw (irq_i),
        .mask_q  (mask_q),
        .wake_q  (wake_q),
        .code_q  (code_q),
        .rdata   (bus_rdata_o)
    );

    pim_route u_route (
        .clk     (clk),
        .rst     (rst),
        .irq_raw (irq_i),
        .mask_q  (mask_q),
        .code_q  (code_q),
        .lvl_q   (lvl_irq_o)
    );

    pim_wake u_wake (
        .clk     (clk),
        .rst     (rst),
        .idle_i  (idle_i),
        .irq_raw (irq_i),
        .wake_q  (wake_q),
        .wake_o  (wake_o)
    );

    // R7
    status_live_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr_i == 3'd1) |-> (bus_rdata_o == irq_i));
endmodule

// File: tb/irq_level_router_tb.sv
module irq_level_router_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq = '0;
    logic        idle = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [8:0]  lvl;
    logic        wake;

    always #5 clk = ~clk;

    irq_level_router u_dut (
        .clk(clk), .rst(rst), .irq_i(irq), .idle_i(idle),
        .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .lvl_irq_o(lvl), .wake_o(wake)
    );

    int    n_run = 0;
    int    n_fail = 0;
    string cur_tag = "R1";
    bit    done = 0;

    logic [31:0] m_mask, m_wen;
    int          m_code [32];
    logic [8:0]  m_lvl;

    function automatic int dflt(input int s);
        int lv;
        if (s < 7) lv = 7;
        else if (s < 9) lv = 8;
        else if (s < 13) lv = 9;
        else if (s < 16) lv = 10;
        else if (s < 19) lv = 11;
        else if (s < 21) lv = 12;
        else if (s < 24) lv = 13;
        else lv = 7;
        return lv - 7;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mask = '0;
            m_wen  = '0;
            m_lvl  = '0;
            for (int s = 0; s < 32; s++) m_code[s] = dflt(s);
        end else begin
            m_lvl = '0;
            for (int l = 0; l < 9; l++)
                for (int s = 0; s < 32; s++)
                    if (irq[s] && m_mask[s] && m_code[s] == l) m_lvl[l] = 1'b1;
            if (we) begin
                if (addr == 3'd0) m_mask = wdata;
                else if (addr == 3'd2) m_wen = wdata;
                else if (addr >= 3'd4)
                    for (int f = 0; f < 8; f++)
                        m_code[(int'(addr) - 4) * 8 + f] = int'(wdata[f*4 +: 4]);
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            3'd0: v = m_mask;
            3'd1: v = irq;
            3'd2: v = m_wen;
            3'd3: v = '0;
            default:
                for (int f = 0; f < 8; f++)
                    v[f*4 +: 4] = 4'(m_code[(int'(a) - 4) * 8 + f]);
        endcase
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (!rst) begin
            chk({"R4 level outputs, phase ", cur_tag}, 32'(lvl), 32'(m_lvl));
            chk({"R10 wake, phase ", cur_tag}, 32'(wake), 32'(idle && |(irq & m_wen)));
            case (addr)
                3'd1:    chk({"R7 status read, phase ", cur_tag}, rdata, exp_rd(addr));
                3'd0, 3'd2, 3'd3:
                         chk({"R11 mask/wake/spare read, phase ", cur_tag}, rdata, exp_rd(addr));
                default: chk({"R3 routing read, phase ", cur_tag}, rdata, exp_rd(addr));
            endcase
        end
    end

    task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d,
                       input logic [31:0] i, input logic id);
        @(negedge clk);
        we = w; addr = a; wdata = d; irq = i; idle = id;
    endtask

    logic [31:0] lf = 32'h1ACE_B00C;
    task automatic step_lf();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 and R2: reset state and default routing read back
        cur_tag = "R1";
        cyc(0, 3'd0, '0, '0, 0);
        cyc(0, 3'd2, '0, '0, 0);
        cur_tag = "R2";
        for (int a = 4; a < 8; a++) cyc(0, 3'(a), '0, '0, 0);
        // R2 / R4: walk each source with all unmasked
        cyc(1, 3'd0, 32'hFFFF_FFFF, '0, 0);
        for (int s = 0; s < 32; s++) cyc(0, 3'd1, '0, 32'h1 << s, 0);
        cyc(0, 3'd1, '0, '0, 0);
        // R6: shared levels OR together
        cur_tag = "R6";
        cyc(0, 3'd1, '0, 32'h0000_007F, 0);
        cyc(0, 3'd1, '0, 32'h0000_0003, 0);
        cyc(0, 3'd1, '0, 32'h00E0_0180, 0);
        cyc(0, 3'd1, '0, 32'hFFFF_FFFF, 0);
        // R5 and R7: mask blocks level, status still raw
        cur_tag = "R5";
        cyc(1, 3'd0, 32'h0000_00F0, 32'hFFFF_FFFF, 0);
        cyc(0, 3'd1, '0, 32'hFFFF_FF0F, 0);
        cyc(0, 3'd1, '0, 32'h0000_0010, 0);
        cyc(1, 3'd0, 32'h0000_0000, 32'hFFFF_FFFF, 0);
        cur_tag = "R7";
        cyc(0, 3'd1, '0, 32'hA5A5_5A5A, 0);
        cyc(0, 3'd1, '0, 32'h0F0F_F0F0, 0);
        // R8: status write ignored
        cur_tag = "R8";
        cyc(1, 3'd1, 32'hDEAD_BEEF, 32'h0000_1234, 0);
        cyc(0, 3'd1, '0, 32'h0000_1234, 0);
        cyc(0, 3'd0, '0, '0, 0);
        cyc(0, 3'd2, '0, '0, 0);
        for (int a = 4; a < 8; a++) cyc(0, 3'(a), '0, '0, 0);
        // R3: rewrite routing and walk sources
        cur_tag = "R3";
        cyc(1, 3'd4, 32'h8765_4321, '0, 0);
        cyc(1, 3'd5, 32'h0123_4567, '0, 0);
        cyc(1, 3'd6, 32'h8888_0000, '0, 0);
        cyc(1, 3'd7, 32'h3535_7171, '0, 0);
        cyc(1, 3'd0, 32'hFFFF_FFFF, '0, 0);
        for (int a = 4; a < 8; a++) cyc(0, 3'(a), '0, '0, 0);
        for (int s = 0; s < 32; s++) cyc(0, 3'd4, '0, 32'h1 << s, 0);
        // R9: codes 9..15 route nowhere
        cur_tag = "R9";
        cyc(1, 3'd4, 32'hFEDC_BA9F, '0, 0);
        for (int s = 0; s < 8; s++) cyc(0, 3'd4, '0, 32'h1 << s, 0);
        cyc(0, 3'd4, '0, 32'h0000_00FF, 0);
        // R10: wake path independent of mask
        cur_tag = "R10";
        cyc(1, 3'd0, 32'h0000_0000, '0, 0);
        cyc(1, 3'd2, 32'h0000_8001, '0, 1);
        cyc(0, 3'd2, '0, 32'h0000_0001, 1);
        cyc(0, 3'd2, '0, 32'h0000_0001, 0);
        cyc(0, 3'd2, '0, 32'h0000_0002, 1);
        cyc(0, 3'd2, '0, 32'h0000_8000, 1);
        cyc(0, 3'd2, '0, 32'hFFFF_7FFE, 1);
        // R11: spare address
        cur_tag = "R11";
        cyc(1, 3'd3, 32'hFFFF_FFFF, '0, 0);
        cyc(0, 3'd3, '0, '0, 0);
        cyc(0, 3'd0, '0, '0, 0);
        cyc(0, 3'd2, '0, '0, 0);
        // mixed traffic
        cur_tag = "mix";
        for (int n = 0; n < 400; n++) begin
            logic        w;
            logic [2:0]  a;
            logic [31:0] d, i;
            logic        id;
            step_lf(); w = (lf[2:0] == 3'd0); a = lf[6:4]; id = lf[9];
            step_lf(); d = lf;
            step_lf(); i = lf & {lf[15:0], lf[31:16]};
            cyc(w, a, d, i, id);
        end
        cyc(0, 3'd0, '0, '0, 0);
        @(negedge clk);
        #4;
        done = 1;
        finish_run();
    end
endmodule